// File: doc/BRIEF.md
# Virtualization Event Exit Decider

This block sits beside a guest execution pipeline and decides, for every guest event, whether it leaves the guest (a virtual-machine exit), goes to the guest's own vector table, or is dropped. It handles four event sources:

- external interrupts, which carry an 8-bit vector;
- exceptions, which carry a vector from 0 to 31;
- guest writes to its task-priority value;
- the moment the guest re-enables interrupts.

A set of configuration registers decides the routing. They are loaded together by a single write strobe and cleared by synchronous reset.

Each decision comes out one clock after its input strobe, as a one-cycle strobe on exactly one of the exit, deliver or discard outputs. An exit also carries a reason code, and every decision carries the vector it concerns. A shadow copy of the guest's task-priority value is kept and exposed, so the hypervisor can read it without trapping every write. Fetching descriptors, saving guest state and the injection mechanics belong to other blocks.

Top module: `vexit_decider`

## Requirements
- R1: After synchronous reset all outputs are 0, the priority shadow reads 0 and every configuration field is 0. With the fields at 0, an external interrupt at vector 32 or above is delivered when the interrupt-enable flag is 1, and raising that flag gives no exit.
- R2: Every decision appears on the outputs exactly one clock after the input strobe that caused it. At most one of exit, deliver and discard is high in a cycle. The reason output is 0 unless exit is high, and the vector output is 0 when no strobe is high.
- R3: With external-interrupt exiting set, an external interrupt with vector 32..255 gives exit with reason 1 and the vector on the vector output, whatever the interrupt-enable flag holds.
- R4: With external-interrupt exiting clear and the interrupt-enable flag at 0, an external interrupt with vector 32..255 gives discard with its vector.
- R5: With external-interrupt exiting clear and the interrupt-enable flag at 1, an external interrupt with vector 32..255 gives deliver with its vector.
- R6: An external-interrupt strobe with a vector below 32 gives no strobe at all.
- R7: An exception with vector v (0..31) gives exit with reason 0 when bit v of the 32-bit exception map is 1. It gives deliver when that bit is 0. In both cases the vector output carries v.
- R8: With priority shadowing enabled, a guest priority write stores its value in the shadow, which is visible one clock later. It gives exit with reason 43 exactly when the value is strictly below the configured threshold, and otherwise gives no strobe.
- R9: With priority shadowing disabled, a guest priority write has no effect: the shadow keeps its value and no strobe follows.
- R10: With window exiting set, the interrupt-enable flag going from 0 in one cycle to 1 in the next gives one exit with reason 7 and vector 0. The flag staying at 1 gives no further window exit. With window exiting clear, a rising flag gives no exit.
- R11: When strobes meet in one cycle, exception beats external interrupt, which beats an exiting priority write, which beats the window exit. A losing exception, interrupt or priority-write decision is dropped, though a priority write still updates the shadow. A window exit that loses is held and issued in the first later cycle with no other decision, provided the flag and window exiting both stay 1; otherwise it is dropped.
- R12: A configuration write captures all control fields on one clock edge, and the new values govern strobes from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Load all configuration fields |
| cfg_ext_exit | input | 1 | External-interrupt exiting control |
| cfg_win_exit | input | 1 | Interrupt-window exiting control |
| cfg_exc_map | input | EXC_N (32) | Exception exit map, one bit per vector |
| cfg_prio_en | input | 1 | Priority shadowing enable |
| cfg_prio_thresh | input | PRIO_W (4) | Priority exit threshold |
| guest_ie | input | 1 | Guest interrupt-enable flag |
| exc_vld | input | 1 | Exception strobe |
| exc_vec | input | log2(EXC_N) (5) | Exception vector |
| ext_vld | input | 1 | External-interrupt strobe |
| ext_vec | input | VEC_W (8) | External-interrupt vector |
| prio_wr_vld | input | 1 | Guest priority-write strobe |
| prio_wr_val | input | PRIO_W (4) | Written priority value |
| exit_o | output | 1 | Exit decision strobe |
| deliver_o | output | 1 | Delivery decision strobe |
| discard_o | output | 1 | Discard decision strobe |
| reason_o | output | REASON_W (6) | Exit reason code |
| vec_o | output | VEC_W (8) | Vector of the decided event |
| prio_shadow_o | output | PRIO_W (4) | Priority shadow value |

## Verification
The bench builds the block with its default parameters: an 8-bit vector, 32 exception vectors, a 4-bit priority and the shadow variant enabled. These sizes allow complete sweeps:

- all 256 external vectors under each of the four combinations of exiting control and interrupt-enable flag;
- every exception vector against four map patterns;
- every priority value against every threshold, 256 pairs, which covers the strict-below boundary at both ends.

Directed sequences then cover the window edge, its deferral behind a concurrent interrupt, and its loss when the flag drops first.

// File: rtl/vexit_pkg.sv
package vexit_pkg;

   typedef enum logic [1:0] {
      ACT_NONE,
      ACT_EXIT,
      ACT_DELIVER,
      ACT_DISCARD
   } vexit_act_e;

   localparam int unsigned RSN_EXC  = 0;
   localparam int unsigned RSN_EXT  = 1;
   localparam int unsigned RSN_WIN  = 7;
   localparam int unsigned RSN_PRIO = 43;

endpackage

// File: rtl/vexit_cfg_regs.sv
module vexit_cfg_regs #(
   parameter int EXC_N  = 32,
   parameter int PRIO_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic              ext_exit_d,
   input  logic              win_exit_d,
   input  logic [EXC_N-1:0]  exc_map_d,
   input  logic              prio_en_d,
   input  logic [PRIO_W-1:0] prio_thr_d,
   output logic              ext_exit_q,
   output logic              win_exit_q,
   output logic [EXC_N-1:0]  exc_map_q,
   output logic              prio_en_q,
   output logic [PRIO_W-1:0] prio_thr_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         ext_exit_q <= 1'b0;
         win_exit_q <= 1'b0;
         exc_map_q  <= '0;
         prio_en_q  <= 1'b0;
         prio_thr_q <= '0;
      end else if (we) begin
         ext_exit_q <= ext_exit_d;
         win_exit_q <= win_exit_d;
         exc_map_q  <= exc_map_d;
         prio_en_q  <= prio_en_d;
         prio_thr_q <= prio_thr_d;
      end
   end

endmodule

// File: rtl/vexit_window.sv
module vexit_window (
   input  logic clk,
   input  logic rst,
   input  logic win_en,
   input  logic guest_ie,
   input  logic slot_busy,
   output logic win_req
);

   logic ie_q;
   logic pend_q;
   logic rise;

   assign rise    = guest_ie & ~ie_q;
   assign win_req = win_en & (rise | (pend_q & guest_ie));

   always_ff @(posedge clk) begin
      if (rst) begin
         ie_q   <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         ie_q <= guest_ie;
         if (!win_en || !guest_ie)
            pend_q <= 1'b0;
         else if (win_req)
            pend_q <= slot_busy;
      end
   end

endmodule

// File: rtl/vexit_classify.sv
module vexit_classify
   import vexit_pkg::*;
#(
   parameter int VEC_W     = 8,
   parameter int EXC_N     = 32,
   parameter int REASON_W  = 6,
   parameter int EXT_FIRST = 32,
   localparam int EXC_IDX_W = $clog2(EXC_N)
) (
   input  logic                 ext_exit_en,
   input  logic [EXC_N-1:0]     exc_map,
   input  logic                 guest_ie,
   input  logic                 exc_vld,
   input  logic [EXC_IDX_W-1:0] exc_vec,
   input  logic                 ext_vld,
   input  logic [VEC_W-1:0]     ext_vec,
   input  logic                 prio_vld,
   input  logic                 prio_below,
   input  logic                 win_req,
   output vexit_act_e           act,
   output logic [REASON_W-1:0]  reason,
   output logic [VEC_W-1:0]     vec,
   output logic                 slot_busy
);

   logic ext_ok;
   assign ext_ok    = ext_vld && (ext_vec >= VEC_W'(EXT_FIRST));
   assign slot_busy = exc_vld | ext_ok | (prio_vld & prio_below);

   always_comb begin
      act    = ACT_NONE;
      reason = '0;
      vec    = '0;
      if (exc_vld) begin
         act    = exc_map[exc_vec] ? ACT_EXIT : ACT_DELIVER;
         reason = REASON_W'(RSN_EXC);
         vec    = VEC_W'(exc_vec);
      end else if (ext_ok) begin
         vec = ext_vec;
         if (ext_exit_en) begin
            act    = ACT_EXIT;
            reason = REASON_W'(RSN_EXT);
         end else if (guest_ie) begin
            act = ACT_DELIVER;
         end else begin
            act = ACT_DISCARD;
         end
      end else if (prio_vld && prio_below) begin
         act    = ACT_EXIT;
         reason = REASON_W'(RSN_PRIO);
      end else if (win_req) begin
         act    = ACT_EXIT;
         reason = REASON_W'(RSN_WIN);
      end
   end

endmodule

// File: rtl/vexit_decider.sv
module vexit_decider
   import vexit_pkg::*;
#(
   parameter int VEC_W       = 8,
   parameter int EXC_N       = 32,
   parameter int PRIO_W      = 4,
   parameter int REASON_W    = 6,
   parameter int EXT_FIRST   = 32,
   parameter bit PRIO_SHADOW = 1'b1,
   localparam int EXC_IDX_W  = $clog2(EXC_N)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 cfg_we,
   input  logic                 cfg_ext_exit,
   input  logic                 cfg_win_exit,
   input  logic [EXC_N-1:0]     cfg_exc_map,
   input  logic                 cfg_prio_en,
   input  logic [PRIO_W-1:0]    cfg_prio_thresh,
   input  logic                 guest_ie,
   input  logic                 exc_vld,
   input  logic [EXC_IDX_W-1:0] exc_vec,
   input  logic                 ext_vld,
   input  logic [VEC_W-1:0]     ext_vec,
   input  logic                 prio_wr_vld,
   input  logic [PRIO_W-1:0]    prio_wr_val,
   output logic                 exit_o,
   output logic                 deliver_o,
   output logic                 discard_o,
   output logic [REASON_W-1:0]  reason_o,
   output logic [VEC_W-1:0]     vec_o,
   output logic [PRIO_W-1:0]    prio_shadow_o
);

   if (VEC_W < 6 || VEC_W > 16) begin : g_bad_vec_w
      $error("vexit_decider: VEC_W out of range");
   end
   if ((1 << EXC_IDX_W) != EXC_N || EXC_N > (1 << VEC_W)) begin : g_bad_exc_n
      $error("vexit_decider: EXC_N must be a power of two that fits VEC_W");
   end
   if (EXT_FIRST < EXC_N || EXT_FIRST >= (1 << VEC_W)) begin : g_bad_ext_first
      $error("vexit_decider: EXT_FIRST out of range");
   end
   if (REASON_W < 6) begin : g_bad_reason_w
      $error("vexit_decider: REASON_W too narrow for reason codes");
   end
   if (PRIO_W < 1 || PRIO_W > 8) begin : g_bad_prio_w
      $error("vexit_decider: PRIO_W out of range");
   end

   logic              cfg_ext_q;
   logic              cfg_win_q;
   logic [EXC_N-1:0]  cfg_map_q;
   logic              shadow_en_q;
   logic [PRIO_W-1:0] thr_q;

   vexit_cfg_regs #(.EXC_N(EXC_N), .PRIO_W(PRIO_W)) u_cfg (
      .clk        (clk),
      .rst        (rst),
      .we         (cfg_we),
      .ext_exit_d (cfg_ext_exit),
      .win_exit_d (cfg_win_exit),
      .exc_map_d  (cfg_exc_map),
      .prio_en_d  (cfg_prio_en),
      .prio_thr_d (cfg_prio_thresh),
      .ext_exit_q (cfg_ext_q),
      .win_exit_q (cfg_win_q),
      .exc_map_q  (cfg_map_q),
      .prio_en_q  (shadow_en_q),
      .prio_thr_q (thr_q)
   );

   logic prio_vld_g;
   logic prio_below;

   if (PRIO_SHADOW) begin : g_shadow
      logic [PRIO_W-1:0] shadow_q;
      always_ff @(posedge clk) begin
         if (rst)
            shadow_q <= '0;
         else if (prio_wr_vld && shadow_en_q)
            shadow_q <= prio_wr_val;
      end
      assign prio_vld_g    = prio_wr_vld & shadow_en_q;
      assign prio_below    = prio_wr_val < thr_q;
      assign prio_shadow_o = shadow_q;
   end else begin : g_no_shadow
      assign prio_vld_g    = 1'b0;
      assign prio_below    = 1'b0;
      assign prio_shadow_o = '0;
   end

   logic                win_req;
   logic                slot_busy;
   vexit_act_e          act;
   logic [REASON_W-1:0] reason;
   logic [VEC_W-1:0]    vec;

   vexit_window u_win (
      .clk       (clk),
      .rst       (rst),
      .win_en    (cfg_win_q),
      .guest_ie  (guest_ie),
      .slot_busy (slot_busy),
      .win_req   (win_req)
   );

   vexit_classify #(
      .VEC_W     (VEC_W),
      .EXC_N     (EXC_N),
      .REASON_W  (REASON_W),
      .EXT_FIRST (EXT_FIRST)
   ) u_cls (
      .ext_exit_en (cfg_ext_q),
      .exc_map     (cfg_map_q),
      .guest_ie    (guest_ie),
      .exc_vld     (exc_vld),
      .exc_vec     (exc_vec),
      .ext_vld     (ext_vld),
      .ext_vec     (ext_vec),
      .prio_vld    (prio_vld_g),
      .prio_below  (prio_below),
      .win_req     (win_req),
      .act         (act),
      .reason      (reason),
      .vec         (vec),
      .slot_busy   (slot_busy)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         exit_o    <= 1'b0;
         deliver_o <= 1'b0;
         discard_o <= 1'b0;
         reason_o  <= '0;
         vec_o     <= '0;
      end else begin
         exit_o    <= (act == ACT_EXIT);
         deliver_o <= (act == ACT_DELIVER);
         discard_o <= (act == ACT_DISCARD);
         reason_o  <= (act == ACT_EXIT) ? reason : '0;
         vec_o     <= (act != ACT_NONE) ? vec : '0;
      end
   end

endmodule

// File: rtl/vexit_decider_chk.sv
module vexit_decider_chk
   import vexit_pkg::*;
#(
   parameter int VEC_W     = 8,
   parameter int EXC_N     = 32,
   parameter int PRIO_W    = 4,
   parameter int REASON_W  = 6,
   parameter int EXT_FIRST = 32,
   localparam int EXC_IDX_W = $clog2(EXC_N)
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 cfg_ext_q,
   input logic [EXC_N-1:0]     cfg_map_q,
   input logic                 shadow_en_q,
   input logic [PRIO_W-1:0]    thr_q,
   input logic                 guest_ie,
   input logic                 exc_vld,
   input logic [EXC_IDX_W-1:0] exc_vec,
   input logic                 ext_vld,
   input logic [VEC_W-1:0]     ext_vec,
   input logic                 prio_wr_vld,
   input logic [PRIO_W-1:0]    prio_wr_val,
   input logic                 exit_o,
   input logic                 deliver_o,
   input logic                 discard_o,
   input logic [REASON_W-1:0]  reason_o,
   input logic [VEC_W-1:0]     vec_o
);

   logic ext_hi;
   assign ext_hi = ext_vld && (ext_vec >= VEC_W'(EXT_FIRST));

   // R2
   one_route_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0({exit_o, deliver_o, discard_o}));

   // R2
   reason_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !exit_o |-> reason_o == '0);

   // R3
   ext_exit_chk: assert property (@(posedge clk) disable iff (rst)
      (!exc_vld && ext_hi && cfg_ext_q) |=> (exit_o && reason_o == REASON_W'(RSN_EXT)));

   // R4
   ext_discard_chk: assert property (@(posedge clk) disable iff (rst)
      (!exc_vld && ext_hi && !cfg_ext_q && !guest_ie) |=> discard_o);

   // R7
   exc_exit_chk: assert property (@(posedge clk) disable iff (rst)
      (exc_vld && cfg_map_q[exc_vec]) |=>
         (exit_o && reason_o == REASON_W'(RSN_EXC) && vec_o == VEC_W'($past(exc_vec))));

   // R7
   exc_deliver_chk: assert property (@(posedge clk) disable iff (rst)
      (exc_vld && !cfg_map_q[exc_vec]) |=> deliver_o);

   // R8
   prio_exit_chk: assert property (@(posedge clk) disable iff (rst)
      (prio_wr_vld && shadow_en_q && prio_wr_val < thr_q && !exc_vld && !ext_hi) |=>
         (exit_o && reason_o == REASON_W'(RSN_PRIO)));

   // R10
   win_flag_chk: assert property (@(posedge clk) disable iff (rst)
      (exit_o && reason_o == REASON_W'(RSN_WIN)) |-> $past(guest_ie));

endmodule

bind vexit_decider vexit_decider_chk #(
   .VEC_W     (VEC_W),
   .EXC_N     (EXC_N),
   .PRIO_W    (PRIO_W),
   .REASON_W  (REASON_W),
   .EXT_FIRST (EXT_FIRST)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .cfg_ext_q   (cfg_ext_q),
   .cfg_map_q   (cfg_map_q),
   .shadow_en_q (shadow_en_q),
   .thr_q       (thr_q),
   .guest_ie    (guest_ie),
   .exc_vld     (exc_vld),
   .exc_vec     (exc_vec),
   .ext_vld     (ext_vld),
   .ext_vec     (ext_vec),
   .prio_wr_vld (prio_wr_vld),
   .prio_wr_val (prio_wr_val),
   .exit_o      (exit_o),
   .deliver_o   (deliver_o),
   .discard_o   (discard_o),
   .reason_o    (reason_o),
   .vec_o       (vec_o)
);

// File: tb/sim_vexit_decider.sv
`timescale 1ns/1ps
module sim_vexit_decider;

   logic        clk = 1'b0;
   logic        rst;
   logic        cfg_we, cfg_ext_exit, cfg_win_exit, cfg_prio_en;
   logic [31:0] cfg_exc_map;
   logic [3:0]  cfg_prio_thresh;
   logic        guest_ie, exc_vld, ext_vld, prio_wr_vld;
   logic [4:0]  exc_vec;
   logic [7:0]  ext_vec;
   logic [3:0]  prio_wr_val;
   logic        exit_o, deliver_o, discard_o;
   logic [5:0]  reason_o;
   logic [7:0]  vec_o;
   logic [3:0]  prio_shadow_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   vexit_decider u0 (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ext_exit(cfg_ext_exit),
      .cfg_win_exit(cfg_win_exit), .cfg_exc_map(cfg_exc_map), .cfg_prio_en(cfg_prio_en),
      .cfg_prio_thresh(cfg_prio_thresh), .guest_ie(guest_ie), .exc_vld(exc_vld),
      .exc_vec(exc_vec), .ext_vld(ext_vld), .ext_vec(ext_vec), .prio_wr_vld(prio_wr_vld),
      .prio_wr_val(prio_wr_val), .exit_o(exit_o), .deliver_o(deliver_o),
      .discard_o(discard_o), .reason_o(reason_o), .vec_o(vec_o), .prio_shadow_o(prio_shadow_o)
   );

   task automatic check_out(input string tag, input bit ex, input bit dl, input bit ds,
                            input int rs, input int vc);
      checks++;
      if (exit_o !== ex || deliver_o !== dl || discard_o !== ds ||
          reason_o !== 6'(rs) || vec_o !== 8'(vc)) begin
         failures++;
         $display("FAIL %s: exit/deliver/discard/reason/vec = %b%b%b/%0d/%0d expected %b%b%b/%0d/%0d",
                  tag, exit_o, deliver_o, discard_o, reason_o, vec_o, ex, dl, ds, rs, vc);
      end
   endtask

   task automatic check_shadow(input string tag, input int exp);
      checks++;
      if (prio_shadow_o !== 4'(exp)) begin
         failures++;
         $display("FAIL %s: shadow = %0d expected %0d", tag, prio_shadow_o, exp);
      end
   endtask

   task automatic load_cfg(input bit ext, input bit win, input logic [31:0] map,
                           input bit pen, input int thr);
      cfg_ext_exit = ext; cfg_win_exit = win; cfg_exc_map = map;
      cfg_prio_en = pen; cfg_prio_thresh = 4'(thr); cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: run did not end, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; cfg_we = 0; cfg_ext_exit = 0; cfg_win_exit = 0; cfg_exc_map = '0;
      cfg_prio_en = 0; cfg_prio_thresh = 0; guest_ie = 0; exc_vld = 0; exc_vec = 0;
      ext_vld = 0; ext_vec = 0; prio_wr_vld = 0; prio_wr_val = 0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1 reset state
      check_out("R1 reset outputs", 0, 0, 0, 0, 0);
      check_shadow("R1 reset shadow", 0);
      // R1 controls cleared: window rise gives nothing, interrupt delivered
      guest_ie = 1'b1; ext_vld = 1'b1; ext_vec = 8'd77;
      @(negedge clk);
      check_out("R1 cleared controls deliver", 0, 1, 0, 0, 77);
      ext_vld = 1'b0;
      @(negedge clk);
      check_out("R1 R10 no window exit with control clear", 0, 0, 0, 0, 0);

      // R3 R4 R5 R6 R2 exhaustive external sweep
      for (int m = 0; m < 4; m++) begin
         guest_ie = m[0];
         load_cfg(m[1], 0, '0, 0, 0);
         for (int v = 0; v < 256; v++) begin
            ext_vld = 1'b1; ext_vec = 8'(v);
            @(negedge clk);
            ext_vld = 1'b0;
            if (v < 32)       check_out("R6 low vector ignored", 0, 0, 0, 0, 0);
            else if (m[1])    check_out("R3 external exit", 1, 0, 0, 1, v);
            else if (m[0])    check_out("R5 external deliver", 0, 1, 0, 0, v);
            else              check_out("R4 external discard", 0, 0, 1, 0, v);
         end
         @(negedge clk);
         check_out("R2 idle after strobe", 0, 0, 0, 0, 0);
      end

      // R7 exception sweep over map patterns
      for (int p = 0; p < 4; p++) begin
         logic [31:0] pat;
         pat = (p == 0) ? 32'hA5C3_0F96 : (p == 1) ? 32'h5A3C_F069 :
               (p == 2) ? 32'h0 : 32'hFFFF_FFFF;
         load_cfg(0, 0, pat, 0, 0);
         for (int v = 0; v < 32; v++) begin
            exc_vld = 1'b1; exc_vec = 5'(v);
            @(negedge clk);
            exc_vld = 1'b0;
            if (pat[v]) check_out("R7 exception exit", 1, 0, 0, 0, v);
            else        check_out("R7 exception deliver", 0, 1, 0, 0, v);
         end
      end

      // R8 R12 priority threshold sweep
      guest_ie = 1'b0;
      for (int t = 0; t < 16; t++) begin
         load_cfg(0, 0, '0, 1, t);
         for (int v = 0; v < 16; v++) begin
            prio_wr_vld = 1'b1; prio_wr_val = 4'(v);
            @(negedge clk);
            prio_wr_vld = 1'b0;
            if (v < t) check_out("R8 priority below threshold", 1, 0, 0, 43, 0);
            else       check_out("R8 priority at or above threshold", 0, 0, 0, 0, 0);
            check_shadow("R8 shadow update", v);
         end
      end

      // R9 shadowing disabled
      load_cfg(0, 0, '0, 0, 15);
      prio_wr_vld = 1'b1; prio_wr_val = 4'd3;
      @(negedge clk);
      prio_wr_vld = 1'b0;
      check_out("R9 write ignored no strobe", 0, 0, 0, 0, 0);
      check_shadow("R9 shadow unchanged", 15);

      // R10 window exit on rising flag
      load_cfg(0, 1, '0, 0, 0);
      guest_ie = 1'b1;
      @(negedge clk);
      check_out("R10 window exit", 1, 0, 0, 7, 0);
      @(negedge clk);
      check_out("R10 no repeat while flag held", 0, 0, 0, 0, 0);

      // R11 window deferred behind external exit
      guest_ie = 1'b0;
      load_cfg(1, 1, '0, 0, 0);
      guest_ie = 1'b1; ext_vld = 1'b1; ext_vec = 8'd40;
      @(negedge clk);
      ext_vld = 1'b0;
      check_out("R11 external wins slot", 1, 0, 0, 1, 40);
      @(negedge clk);
      check_out("R11 deferred window exit", 1, 0, 0, 7, 0);
      @(negedge clk);
      check_out("R11 window issued once", 0, 0, 0, 0, 0);

      // R11 deferred window dropped when flag falls
      guest_ie = 1'b0;
      @(negedge clk);
      guest_ie = 1'b1; ext_vld = 1'b1; ext_vec = 8'd200;
      @(negedge clk);
      ext_vld = 1'b0; guest_ie = 1'b0;
      check_out("R11 external wins slot again", 1, 0, 0, 1, 200);
      @(negedge clk);
      check_out("R11 window dropped", 0, 0, 0, 0, 0);

      // R11 exception beats external
      load_cfg(1, 0, 32'h0000_0100, 1, 8);
      exc_vld = 1'b1; exc_vec = 5'd8; ext_vld = 1'b1; ext_vec = 8'd99;
      @(negedge clk);
      exc_vld = 1'b0; ext_vld = 1'b0;
      check_out("R11 exception beats external", 1, 0, 0, 0, 8);

      // R11 external beats priority write, shadow still updates
      ext_vld = 1'b1; ext_vec = 8'd50; prio_wr_vld = 1'b1; prio_wr_val = 4'd2;
      @(negedge clk);
      ext_vld = 1'b0; prio_wr_vld = 1'b0;
      check_out("R11 external beats priority", 1, 0, 0, 1, 50);
      check_shadow("R11 shadow updated on lost slot", 2);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule